// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries out the hardware part of entering an exception handler in a 32-bit core. While idle it looks at four possible causes: a break raised by the core, a bus fault, a non-maskable interrupt and an ordinary hardware interrupt. It decides whether any of them can be taken and picks one by priority. It then chooses the vector number for that cause.

Once it accepts a cause, the block runs a fixed sequence:

- It saves the return address in the proper special register.
- It records the vector index in the exception status word.
- It winds the return address back when the core was in a delay slot.
- It swaps stack pointers when the core was in user mode.
- It shifts the flag word so that the old mode bits are stacked.
- It reads the handler address from the vector table through one instruction-memory read and loads that word into the program counter.

The core holds its inputs steady while `busy` is low. It applies the write strobes in the cycle they are asserted.

Top module: `exc_entry_seq`

## Requirements
- R1: An ordinary interrupt is accepted only when `irq_pending` is high, flag bit 5 (interrupt enable) is set and `irq_lock` is low.
- R2: A non-maskable interrupt is accepted only when its mask-enable flag is set. That flag is bit 9 when `version_in` < 32 and bit 31 otherwise.
- R3: Causes are ranked break, then bus fault, then NMI, then interrupt. The vector is `trap_vec`, `fault_vec`, 0 or `irq_vec` respectively.
- R4: In the cycle after acceptance the return address is presented on `ret_addr`. `nrp_we` strobes it for an NMI and `erp_we` for every other cause, never both.
- R5: `exs_out` carries the 8-bit vector in bits 15:8 and zero in all other bits, strobed by `exs_we` in the same cycle as R4.
- R6: When `dslot_in` is nonzero, the saved return address is `pc_in - dslot_in` and `dslot_clr` pulses with the R4 strobes. Otherwise the saved address is `pc_in` and `dslot_clr` stays low.
- R7: When flag bit 6 (user mode) is set, `usp_out` = `sp_in` and `sp_out` = `ksp_in`, strobed by `usp_we` and `sp_we` with R4. Otherwise neither strobe fires.
- R8: The new flag word is {f[31:30], f[19:0], 10'b0}, where f is the old flag word with the R2 mask-enable bit cleared for an NMI. It is strobed by `flags_we` with R4.
- R9: Two cycles after acceptance, `imem_req` pulses for one cycle with `imem_addr` = (`ebp_in` + 4 × vector) with bit 31 forced to 0.
- R10: In the cycle after `imem_rvalid`, `pc_we` and `done` pulse for one cycle with `pc_out` = `imem_rdata`. `busy` is low in the cycle after that.
- R11: While `busy` is high no cause is accepted, and no R4–R9 strobe fires outside its own step.
- R12: After reset `busy`, `done` and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_req | input | 1 | Break raised by the core |
| bus_fault | input | 1 | Bus fault raised by the core |
| nmi_pending | input | 1 | Non-maskable interrupt request |
| irq_pending | input | 1 | Hardware interrupt request |
| irq_lock | input | 1 | Interrupt lock, blocks ordinary interrupts |
| trap_vec | input | 8 | Vector for a break |
| fault_vec | input | 8 | Vector latched by the translation unit |
| irq_vec | input | 8 | Vector from the interrupt controller |
| pc_in | input | 32 | Current program counter |
| flags_in | input | 32 | Current flag word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| version_in | input | 8 | Version register |
| dslot_in | input | 3 | Delay-slot offset, zero when no slot is active |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| erp_we | output | 1 | Write exception return register |
| nrp_we | output | 1 | Write NMI return register |
| ret_addr | output | 32 | Return address |
| exs_we | output | 1 | Write exception status |
| exs_out | output | 32 | Exception status value |
| flags_we | output | 1 | Write flag word |
| flags_out | output | 32 | New flag word |
| usp_we | output | 1 | Write user stack pointer |
| usp_out | output | 32 | Saved user stack pointer |
| sp_we | output | 1 | Write stack pointer |
| sp_out | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot state |
| imem_req | output | 1 | Vector fetch request |
| imem_addr | output | 32 | Vector fetch address |
| imem_rvalid | input | 1 | Fetch data valid |
| imem_rdata | input | 32 | Fetched handler address |
| pc_we | output | 1 | Load program counter |
| pc_out | output | 32 | Handler address |

## Verification
The bench drives causes at the falling edge. It expects the register strobes of R4–R8 one cycle after the accepting rising edge, the fetch request two cycles after it, and `pc_we`/`done` one cycle after the edge that sees `imem_rvalid`. Every result is sampled at the falling edge inside the cycle it is due. The bench also checks the neighbouring cycles for the absence of strobes. Expected values come from the requirement formulas applied to the driven inputs. The bench sweeps every cause, both delay-slot states and both mode states, then adds the rejected cases, the priority cases and requests raised while busy.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN      = 32,
  parameter int VW        = 8,
  parameter int DSW       = 3,
  parameter int VERW      = 8,
  parameter int I_BIT     = 5,
  parameter int U_BIT     = 6,
  parameter int M_BIT_OLD = 9,
  parameter int M_BIT_NEW = 31,
  parameter int VER_SPLIT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            brk_req,
  input  logic            bus_fault,
  input  logic            nmi_pending,
  input  logic            irq_pending,
  input  logic            irq_lock,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VW-1:0]   irq_vec,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] flags_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] ksp_in,
  input  logic [XLEN-1:0] ebp_in,
  input  logic [VERW-1:0] version_in,
  input  logic [DSW-1:0]  dslot_in,
  output logic            busy,
  output logic            done,
  output logic            erp_we,
  output logic            nrp_we,
  output logic [XLEN-1:0] ret_addr,
  output logic            exs_we,
  output logic [XLEN-1:0] exs_out,
  output logic            flags_we,
  output logic [XLEN-1:0] flags_out,
  output logic            usp_we,
  output logic [XLEN-1:0] usp_out,
  output logic            sp_we,
  output logic [XLEN-1:0] sp_out,
  output logic            dslot_clr,
  output logic            imem_req,
  output logic [XLEN-1:0] imem_addr,
  input  logic            imem_rvalid,
  input  logic [XLEN-1:0] imem_rdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_out
);
  localparam int KEEP = XLEN - 12;

  typedef enum logic [2:0] {IDLE, SAVE, FETCH_REQ, FETCH_WAIT, FIN} st_t;
  st_t st;

  logic            use_old_m, m_en, irq_ok, nmi_ok, take, pick_nmi;
  logic [VW-1:0]   vec_sel;
  logic [XLEN-1:0] m_mask, f_pre, f_new, vaddr;

  logic            nmi_q, swap_q, ds_q;
  logic [VW-1:0]   vec_q;
  logic [XLEN-1:0] ret_q, flags_q, sp_q, ksp_q, addr_q, data_q;

  assign use_old_m = version_in < VERW'(VER_SPLIT);
  assign m_mask    = use_old_m ? (XLEN'(1) << M_BIT_OLD) : (XLEN'(1) << M_BIT_NEW);
  assign m_en      = |(flags_in & m_mask);
  assign irq_ok    = irq_pending & flags_in[I_BIT] & ~irq_lock;
  assign nmi_ok    = nmi_pending & m_en;
  assign take      = (st == IDLE) & (brk_req | bus_fault | nmi_ok | irq_ok);
  assign pick_nmi  = ~brk_req & ~bus_fault & nmi_ok;

  always_comb begin
    if (brk_req)        vec_sel = trap_vec;
    else if (bus_fault) vec_sel = fault_vec;
    else if (nmi_ok)    vec_sel = '0;
    else                vec_sel = irq_vec;
  end

  assign f_pre = pick_nmi ? (flags_in & ~m_mask) : flags_in;
  assign f_new = {f_pre[XLEN-1:XLEN-2], f_pre[KEEP-1:0], 10'b0};
  assign vaddr = ebp_in + (XLEN'(vec_sel) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      nmi_q <= 1'b0; swap_q <= 1'b0; ds_q <= 1'b0;
      vec_q <= '0; ret_q <= '0; flags_q <= '0; sp_q <= '0;
      ksp_q <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      case (st)
        IDLE: if (take) begin
          st      <= SAVE;
          nmi_q   <= pick_nmi;
          vec_q   <= vec_sel;
          ret_q   <= pc_in - XLEN'(dslot_in);
          ds_q    <= |dslot_in;
          flags_q <= f_new;
          swap_q  <= flags_in[U_BIT];
          sp_q    <= sp_in;
          ksp_q   <= ksp_in;
          addr_q  <= {1'b0, vaddr[XLEN-2:0]};
        end
        SAVE:       st <= FETCH_REQ;
        FETCH_REQ:  st <= FETCH_WAIT;
        FETCH_WAIT: if (imem_rvalid) begin
          st     <= FIN;
          data_q <= imem_rdata;
        end
        default:    st <= IDLE;
      endcase
    end
  end

  wire in_save = (st == SAVE);

  assign busy      = (st != IDLE);
  assign erp_we    = in_save & ~nmi_q;
  assign nrp_we    = in_save & nmi_q;
  assign ret_addr  = ret_q;
  assign exs_we    = in_save;
  assign exs_out   = {{(XLEN-VW-8){1'b0}}, vec_q, 8'b0};
  assign flags_we  = in_save;
  assign flags_out = flags_q;
  assign usp_we    = in_save & swap_q;
  assign usp_out   = sp_q;
  assign sp_we     = in_save & swap_q;
  assign sp_out    = ksp_q;
  assign dslot_clr = in_save & ds_q;
  assign imem_req  = (st == FETCH_REQ);
  assign imem_addr = addr_q;
  assign pc_we     = (st == FIN);
  assign pc_out    = data_q;
  assign done      = (st == FIN);

  p_ret_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(erp_we && nrp_we));
  p_strobes_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |-> (erp_we || nrp_we) && flags_we);
  p_exs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |-> (exs_out[7:0] == 8'h00) && (exs_out[XLEN-1:16] == '0));
  p_flags_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (flags_out[9:0] == 10'b0) && !flags_out[U_BIT]);
  p_req_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |=> imem_req);
  p_addr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> !imem_addr[XLEN-1]);
  p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_stack_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we == sp_we);
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic brk_req = 0, bus_fault = 0, nmi_pending = 0, irq_pending = 0, irq_lock = 0;
  logic [7:0] trap_vec = 8'h21, fault_vec = 8'h5A, irq_vec = 8'hC3, version_in = 8'd10;
  logic [31:0] pc_in = 0, flags_in = 0, sp_in = 0, ksp_in = 32'hFFFF_0100, ebp_in = 32'h8000_4000;
  logic [2:0] dslot_in = 0;
  logic busy, done, erp_we, nrp_we, exs_we, flags_we, usp_we, sp_we, dslot_clr, imem_req, pc_we;
  logic [31:0] ret_addr, exs_out, flags_out, usp_out, sp_out, imem_addr, pc_out;
  logic imem_rvalid = 0;
  logic [31:0] imem_rdata = 0;

  exc_entry_seq dut (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_reqs();
    brk_req = 0; bus_fault = 0; nmi_pending = 0; irq_pending = 0;
  endtask

  // cause: 0 break, 1 bus fault, 2 nmi, 3 irq
  task automatic go(input int cause, input int stall, input bit poke);
    logic [7:0] v;
    logic [31:0] f, fe, ra, ad, hd;
    bit u;
    v  = (cause == 0) ? trap_vec : (cause == 1) ? fault_vec : (cause == 2) ? 8'h00 : irq_vec;
    f  = flags_in;
    if (cause == 2) begin
      if (version_in < 32) f[9] = 1'b0; else f[31] = 1'b0;
    end
    fe = {f[31:30], f[19:0], 10'b0};
    ra = pc_in - {29'b0, dslot_in};
    ad = (ebp_in + {22'b0, v, 2'b00}) & 32'h7FFF_FFFF;
    hd = 32'h0001_0000 ^ {24'b0, v} ^ pc_in;
    u  = flags_in[6];
    @(negedge clk);
    idle_reqs();
    chk(busy && exs_we, "R4 save strobe", {31'b0, exs_we}, 1);
    chk(nrp_we == (cause == 2) && erp_we == (cause != 2), "R4 return target",
        {30'b0, nrp_we, erp_we}, (cause == 2) ? 2 : 1);
    chk(ret_addr == ra, "R6 return address", ret_addr, ra);
    chk(dslot_clr == (dslot_in != 0), "R6 slot clear", {31'b0, dslot_clr}, {31'b0, dslot_in != 0});
    chk(exs_out == {16'b0, v, 8'b0}, "R3 R5 status vector", exs_out, {16'b0, v, 8'b0});
    chk(flags_we && flags_out == fe, "R8 flag shift", flags_out, fe);
    chk(usp_we == u && sp_we == u, "R7 swap strobes", {30'b0, usp_we, sp_we}, {30'b0, u, u});
    if (u) chk(usp_out == sp_in && sp_out == ksp_in, "R7 swap values", sp_out, ksp_in);
    @(negedge clk);
    chk(imem_req && imem_addr == ad, "R9 fetch addr", imem_addr, ad);
    chk(!exs_we && !erp_we && !nrp_we, "R11 single save", {31'b0, exs_we}, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (poke) begin nmi_pending = 1; brk_req = 1; irq_pending = 1; end
      chk(!imem_req && !exs_we && !erp_we && !nrp_we && !flags_we && !pc_we, "R11 quiet while busy",
          {31'b0, exs_we | imem_req}, 0);
    end
    @(negedge clk);
    idle_reqs();
    chk(!imem_req && busy && !done, "R9 single request", {31'b0, imem_req}, 0);
    imem_rvalid = 1; imem_rdata = hd;
    @(negedge clk);
    imem_rvalid = 0; imem_rdata = 32'hDEAD_BEEF;
    chk(pc_we && done && pc_out == hd, "R10 pc load", pc_out, hd);
    @(negedge clk);
    chk(!busy && !done && !pc_we, "R10 back to idle", {31'b0, busy}, 0);
  endtask

  task automatic reject(input string tag);
    @(negedge clk);
    chk(!busy && !exs_we && !erp_we && !nrp_we, tag, {31'b0, busy}, 0);
    idle_reqs();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !exs_we && !imem_req && !pc_we, "R12 reset state", {31'b0, busy}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < 5; c++)
      for (int ds = 0; ds < 2; ds++)
        for (int u = 0; u < 2; u++) begin
          pc_in      = 32'h8000_1000 + 32'(c * 256 + ds * 16 + u * 4);
          sp_in      = 32'h0000_7FF0 + 32'(c);
          dslot_in   = ds ? 3'd2 : 3'd0;
          version_in = (c == 4) ? 8'd40 : 8'd10;
          flags_in   = 32'h400A_5000 | 32'h20 | (u ? 32'h40 : 0) | ((c == 4) ? 32'h8000_0000 : 32'h200);
          brk_req     = (c == 0);
          bus_fault   = (c == 1);
          nmi_pending = (c == 2 || c == 4);
          irq_pending = (c == 3);
          go((c == 4) ? 2 : c, 0, 0);
        end

    dslot_in = 0; version_in = 8'd10;
    flags_in = 32'h0000_0200;
    irq_pending = 1;
    reject("R1 enable clear");
    flags_in = 32'h0000_0220; irq_lock = 1; irq_pending = 1;
    reject("R1 locked");
    irq_lock = 0;
    version_in = 8'd40; flags_in = 32'h0000_0220; nmi_pending = 1;
    reject("R2 new position clear");
    version_in = 8'd10; flags_in = 32'h8000_0020; nmi_pending = 1;
    reject("R2 old position clear");

    flags_in = 32'h0000_0220; pc_in = 32'h0000_2000;
    brk_req = 1; bus_fault = 1; nmi_pending = 1; irq_pending = 1;
    go(0, 0, 0);
    bus_fault = 1; nmi_pending = 1; irq_pending = 1;
    go(1, 0, 0);
    nmi_pending = 1; irq_pending = 1;
    go(2, 0, 0);
    irq_pending = 1;
    go(3, 2, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule